// File: doc/BRIEF.md
# Clock-Crossing Packet Word-to-Byte Converter

This block takes framed packets as 32-bit words on a user clock and hands them out as a byte stream on an unrelated transmit clock. Each input word carries a start flag, an end flag and, on the end word only, a 2-bit pad count that says how many low-order bytes of that word are unused. The block stores words in a dual-clock FIFO and serialises each word into bytes, most significant byte first. It drops the pad bytes and rebuilds start and end flags on the byte side.

A packet is released to the byte side only once its end word sits in storage. Once a packet starts it therefore runs without gaps, which suits a downstream transmitter that cannot pause mid-frame. Backpressure to the source is a registered ready signal that falls before storage can overflow. Preamble, CRC and inter-frame spacing belong to later stages.

Top module: `pkbw_txbuf`

## Requirements
- R1: While `rst_n` is low, `byte_vld`, `byte_sop` and `byte_eop` are low. Reset is asynchronous and clears both clock domains. It must be held for at least three `usr_clk` cycles. After release, `word_rdy` is high within two `usr_clk` cycles if no input arrives.
- R2: A packet of N accepted words whose end word carries pad value p (0..3) comes out as exactly 4*N-p bytes. `word_pad` is zero on every non-end word. `word_sop` marks the first word and `word_eop` the last word of each packet.
- R3: Each word leaves most significant byte first: bits [31:24], then [23:16], then [15:8], then [7:0]. On the end word the last p of these positions are dropped.
- R4: `byte_sop` is high together with the first byte of a packet and `byte_eop` together with its last kept byte. Neither is high without `byte_vld`. The next valid byte after an end byte carries `byte_sop`.
- R5: From a packet's start byte to its end byte, `byte_vld` stays high on every `tx_clk` cycle.
- R6: No byte of a packet appears before that packet's end word has been accepted. A packet may hold at most DEPTH words.
- R7: A word is taken only on a `usr_clk` edge where `word_vld` and `word_rdy` are both high. `word_rdy` falls before storage would overflow, so no accepted word is ever lost or overwritten.
- R8: A one-word packet with pad 3 yields a single byte that carries `byte_sop` and `byte_eop` together.
- R9: Packets leave in the order they were accepted, with their boundaries intact, including when several are queued back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| usr_clk | input | 1 | Word-side clock |
| word_in | input | 32 | Input data word |
| word_vld | input | 1 | Input word valid |
| word_sop | input | 1 | First word of a packet |
| word_eop | input | 1 | Last word of a packet |
| word_pad | input | 2 | Count of unused low bytes in the last word |
| word_rdy | output | 1 | Block can accept a word on this edge |
| tx_clk | input | 1 | Byte-side clock |
| byte_out | output | 8 | Output byte |
| byte_vld | output | 1 | Output byte valid |
| byte_sop | output | 1 | First byte of a packet |
| byte_eop | output | 1 | Last byte of a packet |

## Verification
The bench sends every pad value, a one-word pad-3 packet and a packet whose words trickle in with long gaps. With that packet it checks that the first byte comes only after the end word was taken; a design that started on a non-empty FIFO would either start early or leave holes in `byte_vld`. Full-depth packets sent back to back force `word_rdy` low. An overflowing design would corrupt or lose words, and the byte-level comparison would catch it. Distinct values in each byte lane expose a reversed byte order or an off-by-one in the pad trimming as length or data errors.

// File: rtl/pkbw_pkg.sv
package pkbw_pkg;

   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] gray2bin(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) begin
         b[i] = b[i+1] ^ g[i];
      end
      return b;
   endfunction

endpackage

// File: rtl/pkbw_sync.sv
module pkbw_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pkbw_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pkbw_cdc_fifo.sv
module pkbw_cdc_fifo
   import pkbw_pkg::*;
#(
   parameter int DW          = 35,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          rst_n,
   // write domain
   input  logic          wclk,
   input  logic          wr_req,
   input  logic          wr_last,
   input  logic [DW-1:0] wr_data,
   output logic          wr_ready,
   // read domain
   input  logic          rclk,
   input  logic          rd_pop,
   input  logic          rd_take,
   output logic [DW-1:0] rd_data,
   output logic          rd_pkt_pending
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if ((1 << AW) != DEPTH || DEPTH < 4) begin : g_bad_depth
         $error("pkbw_cdc_fifo: DEPTH must be a power of two, at least 4");
      end
      if (PW > 32) begin : g_bad_ptr
         $error("pkbw_cdc_fifo: pointer wider than 32 bits");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];

   // ---------------- write domain ----------------
   logic [PW-1:0] wbin, wgray, wpk_bin, wpk_gray;
   logic [PW-1:0] rgray_w, rbin_w, wbin_nx, wpk_nx;
   logic          wr_fire;

   assign wr_fire = wr_req & wr_ready;
   assign wbin_nx = wbin + PW'(wr_fire);
   assign wpk_nx  = wpk_bin + PW'(wr_fire & wr_last);
   assign rbin_w  = PW'(gray2bin(32'(rgray_w)));

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wbin     <= '0;
         wgray    <= '0;
         wpk_bin  <= '0;
         wpk_gray <= '0;
         wr_ready <= 1'b0;
      end else begin
         wbin     <= wbin_nx;
         wgray    <= PW'(bin2gray(32'(wbin_nx)));
         wpk_bin  <= wpk_nx;
         wpk_gray <= PW'(bin2gray(32'(wpk_nx)));
         wr_ready <= (wbin_nx - rbin_w) < PW'(DEPTH);
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_fire) begin
         mem[wbin[AW-1:0]] <= wr_data;
      end
   end

   // ---------------- read domain ----------------
   logic [PW-1:0] rbin, rgray, rpk_bin;
   logic [PW-1:0] wgray_r, wpk_gray_r, wbin_r, wpk_r, rbin_nx;

   assign rbin_nx        = rbin + PW'(rd_pop);
   assign wbin_r         = PW'(gray2bin(32'(wgray_r)));
   assign wpk_r          = PW'(gray2bin(32'(wpk_gray_r)));
   assign rd_pkt_pending = (wpk_r != rpk_bin);
   assign rd_data        = mem[rbin[AW-1:0]];

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rbin    <= '0;
         rgray   <= '0;
         rpk_bin <= '0;
      end else begin
         rbin    <= rbin_nx;
         rgray   <= PW'(bin2gray(32'(rbin_nx)));
         rpk_bin <= rpk_bin + PW'(rd_take);
      end
   end

   // ---------------- crossings ----------------
   pkbw_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_rptr (
      .clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_w));
   pkbw_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_wptr (
      .clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_r));
   pkbw_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_wpkt (
      .clk(rclk), .rst_n(rst_n), .d(wpk_gray), .q(wpk_gray_r));

   // R7
   no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
      wr_fire |-> ((wbin - rbin_w) < PW'(DEPTH)));

   // R6
   no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
      rd_pop |-> (rbin != wbin_r));
endmodule

// File: rtl/pkbw_serializer.sv
module pkbw_serializer #(
   parameter int WORD_W = 32,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pkt_pending,
   input  logic [WORD_W-1:0] word_in,
   input  logic              eop_in,
   input  logic [$clog2(WORD_W/BYTE_W)-1:0] pad_in,
   output logic              pop,
   output logic              take_pkt,
   output logic [BYTE_W-1:0] byte_out,
   output logic              byte_vld,
   output logic              byte_sop,
   output logic              byte_eop
);
   localparam int LANES = WORD_W / BYTE_W;
   localparam int IW    = $clog2(LANES);

   logic              busy, first, eop_q;
   logic [IW-1:0]     idx, pad_q, last_lane;
   logic [WORD_W-1:0] word_q;
   logic              lane_end, pkt_end, load;
   int                lane;

   assign last_lane = eop_q ? (IW'(LANES - 1) - pad_q) : IW'(LANES - 1);
   assign lane_end  = busy && (idx == last_lane);
   assign pkt_end   = lane_end && eop_q;
   assign take_pkt  = (!busy || pkt_end) && pkt_pending;
   assign load      = take_pkt || (lane_end && !eop_q);
   assign pop       = load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         first  <= 1'b0;
         eop_q  <= 1'b0;
         idx    <= '0;
         pad_q  <= '0;
         word_q <= '0;
      end else if (load) begin
         word_q <= word_in;
         eop_q  <= eop_in;
         pad_q  <= pad_in;
         idx    <= '0;
         busy   <= 1'b1;
         first  <= take_pkt;
      end else if (pkt_end) begin
         busy   <= 1'b0;
         first  <= 1'b0;
      end else if (busy) begin
         idx    <= idx + IW'(1);
         first  <= 1'b0;
      end
   end

   always_comb begin
      lane     = LANES - 1 - int'(idx);
      byte_out = word_q[lane*BYTE_W +: BYTE_W];
   end

   assign byte_vld = busy;
   assign byte_sop = busy && first;
   assign byte_eop = pkt_end;

   // R5
   gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_eop) |=> byte_vld);

   // R4
   sop_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && byte_eop) |=> (!byte_vld || byte_sop));

   // R4
   no_mid_sop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld && !byte_eop) |=> !byte_sop);
endmodule

// File: rtl/pkbw_txbuf.sv
module pkbw_txbuf #(
   parameter int WORD_W      = 32,
   parameter int BYTE_W      = 8,
   parameter int DEPTH       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int LANES      = WORD_W / BYTE_W,
   localparam int PADW       = $clog2(LANES)
) (
   input  logic              rst_n,
   input  logic              usr_clk,
   input  logic [WORD_W-1:0] word_in,
   input  logic              word_vld,
   input  logic              word_sop,
   input  logic              word_eop,
   input  logic [PADW-1:0]   word_pad,
   output logic              word_rdy,
   input  logic              tx_clk,
   output logic [BYTE_W-1:0] byte_out,
   output logic              byte_vld,
   output logic              byte_sop,
   output logic              byte_eop
);
   localparam int DW = WORD_W + PADW + 1;

   generate
      if (WORD_W % BYTE_W != 0 || LANES < 2) begin : g_bad_ratio
         $error("pkbw_txbuf: WORD_W must be a multiple of BYTE_W, ratio >= 2");
      end
      if ((1 << PADW) != LANES) begin : g_bad_lanes
         $error("pkbw_txbuf: lane count must be a power of two");
      end
   endgenerate

   logic [DW-1:0]     rd_entry;
   logic              rd_pop, rd_take, pkt_pending;
   logic [WORD_W-1:0] rd_word;
   logic [PADW-1:0]   rd_pad;
   logic              rd_eop;

   pkbw_cdc_fifo #(.DW(DW), .DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
      .rst_n         (rst_n),
      .wclk          (usr_clk),
      .wr_req        (word_vld),
      .wr_last       (word_eop),
      .wr_data       ({word_eop, word_pad, word_in}),
      .wr_ready      (word_rdy),
      .rclk          (tx_clk),
      .rd_pop        (rd_pop),
      .rd_take       (rd_take),
      .rd_data       (rd_entry),
      .rd_pkt_pending(pkt_pending)
   );

   assign {rd_eop, rd_pad, rd_word} = rd_entry;

   pkbw_serializer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_ser (
      .clk        (tx_clk),
      .rst_n      (rst_n),
      .pkt_pending(pkt_pending),
      .word_in    (rd_word),
      .eop_in     (rd_eop),
      .pad_in     (rd_pad),
      .pop        (rd_pop),
      .take_pkt   (rd_take),
      .byte_out   (byte_out),
      .byte_vld   (byte_vld),
      .byte_sop   (byte_sop),
      .byte_eop   (byte_eop)
   );

   // input framing tracker, used by the checks below
   logic in_frame_q;
   always_ff @(posedge usr_clk or negedge rst_n) begin
      if (!rst_n)                    in_frame_q <= 1'b0;
      else if (word_vld && word_rdy) in_frame_q <= !word_eop;
   end

   // R2
   pad_zero_chk: assert property (@(posedge usr_clk) disable iff (!rst_n)
      (word_vld && word_rdy && !word_eop) |-> (word_pad == '0));

   // R2
   sop_framing_chk: assert property (@(posedge usr_clk) disable iff (!rst_n)
      (word_vld && word_rdy) |-> (word_sop == !in_frame_q));
endmodule

// File: tb/pkbw_txbuf_tb.sv
`timescale 1ns/1ps
module pkbw_txbuf_tb;
   localparam int DEPTH = 16;

   logic        rst_n = 1'b0;
   logic        usr_clk = 1'b0;
   logic        tx_clk = 1'b0;
   logic [31:0] word_in = '0;
   logic        word_vld = 1'b0, word_sop = 1'b0, word_eop = 1'b0;
   logic [1:0]  word_pad = '0;
   logic        word_rdy;
   logic [7:0]  byte_out;
   logic        byte_vld, byte_sop, byte_eop;

   always #10 usr_clk = ~usr_clk;   // 50 MHz
   always #8  tx_clk  = ~tx_clk;

   pkbw_txbuf #(.DEPTH(DEPTH)) u_dut (
      .rst_n(rst_n), .usr_clk(usr_clk), .word_in(word_in), .word_vld(word_vld),
      .word_sop(word_sop), .word_eop(word_eop), .word_pad(word_pad),
      .word_rdy(word_rdy), .tx_clk(tx_clk), .byte_out(byte_out),
      .byte_vld(byte_vld), .byte_sop(byte_sop), .byte_eop(byte_eop));

   int total = 0, bad = 0;
   logic [7:0] exp_bytes[$];
   int         exp_lens[$];
   logic [7:0] rx_bytes[$];
   int         rx_lens[$];
   time        sop_times[$];
   int         cur_len = 0, gap_cnt = 0, stray_cnt = 0;
   bit         in_pkt = 0, rdy_low_seen = 0;
   time        last_eop_accept = 0, last_sop_time = 0;
   int         cyc = 0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // watchdog
   always @(posedge usr_clk) begin
      cyc++;
      if (cyc > 150000) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // byte-side monitor
   always @(negedge tx_clk) begin
      if (rst_n) begin
         if (byte_vld) begin
            if (byte_sop) begin
               if (in_pkt) stray_cnt++;
               in_pkt = 1; cur_len = 0; sop_times.push_back($time);
            end else if (!in_pkt) stray_cnt++;
            rx_bytes.push_back(byte_out);
            cur_len++;
            if (byte_eop) begin rx_lens.push_back(cur_len); in_pkt = 0; end
         end else begin
            if (in_pkt) gap_cnt++;
            if (byte_sop || byte_eop) stray_cnt++;
         end
      end
   end

   function automatic logic [31:0] mk_word(input int pid, input int i);
      return {8'(pid), 8'(i), 8'(i) ^ 8'hA5, 8'(pid + i + 1)};
   endfunction

   task automatic send_pkt(input int pid, input int n, input int pad, input int gap);
      for (int i = 0; i < n; i++) begin
         logic [31:0] w;
         int nb;
         w = mk_word(pid, i);
         @(negedge usr_clk);
         while (!word_rdy) begin
            rdy_low_seen = 1;
            word_vld = 0;
            @(negedge usr_clk);
         end
         word_in  = w;
         word_vld = 1;
         word_sop = (i == 0);
         word_eop = (i == n - 1);
         word_pad = (i == n - 1) ? 2'(pad) : 2'd0;
         if (i == n - 1) last_eop_accept = $time + 10;
         nb = (i == n - 1) ? 4 - pad : 4;
         for (int b = 0; b < nb; b++) exp_bytes.push_back(w[31 - 8*b -: 8]);
         if (gap > 0) begin
            @(negedge usr_clk);
            word_vld = 0; word_sop = 0; word_eop = 0; word_pad = 0;
            repeat (gap - 1) @(negedge usr_clk);
         end
      end
      exp_lens.push_back(n * 4 - pad);
      @(negedge usr_clk);
      word_vld = 0; word_sop = 0; word_eop = 0; word_pad = 0;
   endtask

   task automatic drain_and_check(input string tag);
      int npk;
      npk = exp_lens.size();
      while (rx_lens.size() < npk) @(negedge tx_clk);
      for (int p = 0; p < npk; p++) begin
         int el, rl, mm;
         el = exp_lens.pop_front();
         rl = rx_lens.pop_front();
         last_sop_time = sop_times.pop_front();
         chk(rl == el, {"R2 length ", tag}, rl, el);
         mm = 0;
         for (int b = 0; b < el; b++) begin
            logic [7:0] e, r;
            e = exp_bytes.pop_front();
            r = (rx_bytes.size() > 0) ? rx_bytes.pop_front() : 8'hxx;
            if (r !== e) mm++;
         end
         if (rl > el) repeat (rl - el) void'(rx_bytes.pop_front());
         chk(mm == 0, {"R3 R9 byte data/order ", tag}, mm, 0);
      end
      chk(gap_cnt == 0, {"R5 valid gaps ", tag}, gap_cnt, 0);
      chk(stray_cnt == 0, {"R4 framing flags ", tag}, stray_cnt, 0);
   endtask

   task automatic t_reset();
      // R1
      chk(byte_vld == 0 && byte_sop == 0 && byte_eop == 0, "R1 outputs idle in reset",
          int'(byte_vld), 0);
      @(negedge usr_clk); rst_n = 1;
      repeat (2) @(negedge usr_clk);
      chk(word_rdy == 1, "R1 ready after reset", int'(word_rdy), 1);
      chk(byte_vld == 0, "R1 no output after reset", int'(byte_vld), 0);
   endtask

   task automatic t_all_pads();
      for (int p = 0; p < 4; p++) send_pkt(16 + p, 3 + p, p, 0);
      drain_and_check("pads");
   endtask

   task automatic t_one_word();
      // R8: single byte carrying both flags
      send_pkt(40, 1, 3, 0);
      drain_and_check("R8 one-word");
   endtask

   task automatic t_slow_source();
      // R6
      send_pkt(50, 5, 1, 6);
      drain_and_check("slow");
      chk(last_sop_time > last_eop_accept, "R6 start after end word stored",
          int'(last_sop_time), int'(last_eop_accept));
   endtask

   task automatic t_backpressure();
      // R7 R9
      rdy_low_seen = 0;
      for (int k = 0; k < 3; k++) send_pkt(60 + k, DEPTH, k, 0);
      drain_and_check("R7 full depth");
      chk(rdy_low_seen, "R7 ready fell under load", int'(rdy_low_seen), 1);
   endtask

   task automatic t_burst();
      // R9
      for (int k = 0; k < 5; k++) send_pkt(80 + k, 1 + k % 3, (k * 3) % 4, 0);
      drain_and_check("R9 burst");
   endtask

   initial begin
      repeat (5) @(negedge usr_clk);
      t_reset();
      t_all_pads();
      t_one_word();
      t_slow_source();
      t_backpressure();
      t_burst();
      repeat (20) @(negedge tx_clk);
      chk(byte_vld == 0, "R5 idle after traffic", int'(byte_vld), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule